// File: doc/BRIEF.md
# Vector Register Slide Unit

This block moves the elements of one vector register image up or down by a number of positions and writes the result over the previous destination image. Four operations are available. Two move by an arbitrary offset, taken either from a 64-bit scalar operand or from a 5-bit immediate. The other two move by exactly one position and place the scalar operand in the element slot that is freed. Per-element masking, tail zeroing and the vector-length rules of a vector execution pipeline all apply.

Each operation is a short sequence. A start strobe captures every operand. The block then visits one element per clock from index 0 up to the maximum element count minus one. A done pulse marks the result as final. The states are `S_IDLE`, `S_RUN` and `S_DONE`. In `S_IDLE`, start moves to `S_RUN`, or to `S_DONE` when the operation is illegal or the vector length is zero. In `S_RUN` the block stays until the last index, then moves to `S_DONE`. `S_DONE` always returns to `S_IDLE`. Illegal encodings are reported together with the done pulse and leave the destination untouched.

Top module: `vslide_unit`

## Requirements
- R1: `func_code` 001110 selects an upward move and 001111 a downward move. For `sub_op`, 100 takes the offset from `scalar_in`, 011 takes it from `imm_off` zero-extended, and 110 selects the move-by-one form with scalar insertion. Any other combination is illegal.
- R2: An upward move by offset k sets element i to source element i−k for k ≤ i < vl. Elements below k keep their previous value.
- R3: For an upward move, an offset larger than vl is reduced to vl, so every element below vl keeps its previous value.
- R4: A downward move by offset k sets element i (i < vl) to source element i+k when i+k < vlmax, and to zero otherwise. The offset is never reduced, and may be up to 64 bits wide.
- R5: The upward move-by-one sets element 0 to `scalar_in` truncated to the element width, and element i to source element i−1 for 1 ≤ i < vl.
- R6: The downward move-by-one sets element vl−1 to the truncated `scalar_in`, and element i to source element i+1 for i < vl−1.
- R7: With `unmasked` = 0, an element i < vl whose bit `mask_img[i]` is 0 keeps its previous value.
- R8: When vl > 0, elements vl to vlmax−1 become zero. Bits at or above element vlmax keep their previous value.
- R9: When vl = 0, the result equals the previous destination image.
- R10: An upward move (either form) with `dst_sel` equal to `src_sel` is illegal. `illegal` is high during the done pulse and the result equals the previous image.
- R11: `done` is high for exactly one cycle, vlmax+1 cycles after the start edge (1 cycle for an illegal operation or vl = 0). A start while the block is busy is ignored.
- R12: The element width is 8 << `ew_sel` bits (0 gives 8, 3 gives 64). Element i occupies bits [i*w+w−1 : i*w] of each image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, sampled only when idle |
| func_code | input | 6 | Operation family code |
| sub_op | input | 3 | Offset source / move-by-one selector |
| dst_sel | input | 5 | Destination register number |
| src_sel | input | 5 | Source register number |
| imm_off | input | 5 | Immediate offset |
| scalar_in | input | 64 | Scalar offset or inserted value |
| vl | input | CW | Current vector length |
| vlmax | input | CW | Maximum element count |
| ew_sel | input | 2 | Element width code |
| unmasked | input | 1 | 1 disables masking |
| src_img | input | VLEN | Source register image |
| old_img | input | VLEN | Previous destination image |
| mask_img | input | VLEN | Mask register image, bit i governs element i |
| dst_img | output | VLEN | New destination image |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal encoding, valid with done |

## Verification
The hardest condition to reach is a start strobe that arrives while an operation is already running. It must not disturb the captured operands or the result. The stimulus raises start a few cycles into a long run and changes the source and previous images at the same moment. The final image is then compared against the first operation's expected value. Another narrow case is a downward offset above 2^32: the element index sum only stays in range if the full 64-bit offset is carried through. A huge scalar offset exercises this, and the expected result is an all-zero body.

// File: rtl/slide_pkg.sv
package slide_pkg;
    typedef enum logic [1:0] {OP_UP, OP_DOWN, OP_UP1, OP_DN1} slide_op_e;
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} slide_st_e;

    localparam logic [5:0] FC_UP   = 6'b001110;
    localparam logic [5:0] FC_DOWN = 6'b001111;
    localparam logic [2:0] SO_SCAL = 3'b100;
    localparam logic [2:0] SO_IMM  = 3'b011;
    localparam logic [2:0] SO_ONE  = 3'b110;

    function automatic logic [63:0] elem_ones(input logic [1:0] ew);
        logic [63:0] m;
        unique case (ew)
            2'd0: m = 64'h0000_0000_0000_00FF;
            2'd1: m = 64'h0000_0000_0000_FFFF;
            2'd2: m = 64'h0000_0000_FFFF_FFFF;
            default: m = 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/slide_decode.sv
module slide_decode
    import slide_pkg::*;
(
    input  logic [5:0]  func_code,
    input  logic [2:0]  sub_op,
    input  logic [4:0]  dst_sel,
    input  logic [4:0]  src_sel,
    input  logic [4:0]  imm_off,
    input  logic [63:0] scalar_in,
    output slide_op_e   op,
    output logic [63:0] offset,
    output logic        legal
);
    logic is_up;
    logic is_dn;

    always_comb begin
        is_up  = (func_code == FC_UP);
        is_dn  = (func_code == FC_DOWN);
        legal  = is_up || is_dn;
        op     = OP_UP;
        offset = '0;
        unique case (sub_op)
            SO_SCAL: begin
                offset = scalar_in;
                op     = is_up ? OP_UP : OP_DOWN;
            end
            SO_IMM: begin
                offset = 64'(imm_off);
                op     = is_up ? OP_UP : OP_DOWN;
            end
            SO_ONE: begin
                op     = is_up ? OP_UP1 : OP_DN1;
            end
            default: legal = 1'b0;
        endcase
        // R10: upward forms may not overwrite their own source
        if (is_up && (dst_sel == src_sel)) begin
            legal = 1'b0;
        end
    end
endmodule

// File: rtl/slide_elem.sv
module slide_elem
    import slide_pkg::*;
#(
    parameter int VLEN = 128,
    parameter int CW   = 5
) (
    input  slide_op_e        op,
    input  logic [CW-1:0]    idx,
    input  logic [CW-1:0]    vl,
    input  logic [CW-1:0]    vlmax,
    input  logic [63:0]      offset,
    input  logic [63:0]      scalar_in,
    input  logic [1:0]       ew_sel,
    input  logic             unmasked,
    input  logic             mbit,
    input  logic [VLEN-1:0]  src,
    output logic             wr,
    output logic [63:0]      wdata
);
    logic [63:0]   wm;
    logic [CW-1:0] up_off;
    logic [64:0]   dn_idx;

    function automatic logic [63:0] pick(input logic [VLEN-1:0] img,
                                         input logic [CW-1:0]   j,
                                         input logic [1:0]      ew);
        logic [VLEN-1:0] t;
        t = img >> (int'(j) << (3 + int'(ew)));
        return t[63:0];
    endfunction

    assign wm = elem_ones(ew_sel);

    always_comb begin
        wr     = 1'b0;
        wdata  = '0;
        up_off = (offset > 64'(vl)) ? vl : offset[CW-1:0];   // R3 clamp
        dn_idx = 65'(offset) + 65'(idx);
        if (idx >= vl) begin
            wr = 1'b1;                                        // R8 tail zero
        end else if (unmasked || mbit) begin
            unique case (op)
                OP_UP: begin
                    if (idx >= up_off) begin
                        wr    = 1'b1;
                        wdata = pick(src, idx - up_off, ew_sel) & wm;
                    end
                end
                OP_DOWN: begin
                    wr = 1'b1;
                    if (dn_idx < 65'(vlmax)) begin
                        wdata = pick(src, dn_idx[CW-1:0], ew_sel) & wm;
                    end
                end
                OP_UP1: begin
                    wr    = 1'b1;
                    wdata = (idx == '0) ? (scalar_in & wm)
                                        : (pick(src, idx - CW'(1), ew_sel) & wm);
                end
                OP_DN1: begin
                    wr    = 1'b1;
                    wdata = (idx == vl - CW'(1)) ? (scalar_in & wm)
                                                 : (pick(src, idx + CW'(1), ew_sel) & wm);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vslide_unit.sv
module vslide_unit
    import slide_pkg::*;
#(
    parameter int VLEN = 128,
    localparam int NMAX = VLEN / 8,
    localparam int CW   = $clog2(NMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [5:0]       func_code,
    input  logic [2:0]       sub_op,
    input  logic [4:0]       dst_sel,
    input  logic [4:0]       src_sel,
    input  logic [4:0]       imm_off,
    input  logic [63:0]      scalar_in,
    input  logic [CW-1:0]    vl,
    input  logic [CW-1:0]    vlmax,
    input  logic [1:0]       ew_sel,
    input  logic             unmasked,
    input  logic [VLEN-1:0]  src_img,
    input  logic [VLEN-1:0]  old_img,
    input  logic [VLEN-1:0]  mask_img,
    output logic [VLEN-1:0]  dst_img,
    output logic             done,
    output logic             illegal
);
    slide_st_e       st_q, st_d;
    slide_op_e       dec_op, op_q;
    logic [63:0]     dec_off, off_q, scal_q;
    logic            dec_legal, ill_q, unm_q;
    logic [CW-1:0]   vl_q, vlmax_q, idx_q;
    logic [1:0]      ew_q;
    logic [VLEN-1:0] src_q, old_q, mask_q, res_q;
    logic            el_wr;
    logic [63:0]     el_data;
    logic [VLEN-1:0] fmask, fdata;

    slide_decode u_dec (
        .func_code (func_code),
        .sub_op    (sub_op),
        .dst_sel   (dst_sel),
        .src_sel   (src_sel),
        .imm_off   (imm_off),
        .scalar_in (scalar_in),
        .op        (dec_op),
        .offset    (dec_off),
        .legal     (dec_legal)
    );

    slide_elem #(.VLEN(VLEN), .CW(CW)) u_elem (
        .op        (op_q),
        .idx       (idx_q),
        .vl        (vl_q),
        .vlmax     (vlmax_q),
        .offset    (off_q),
        .scalar_in (scal_q),
        .ew_sel    (ew_q),
        .unmasked  (unm_q),
        .mbit      (mask_q[idx_q]),
        .src       (src_q),
        .wr        (el_wr),
        .wdata     (el_data)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (start) st_d = (!dec_legal || vl == '0) ? S_DONE : S_RUN;
            S_RUN:  if (idx_q == vlmax_q - CW'(1)) st_d = S_DONE;
            S_DONE: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // element field placement (R12 little-endian packing)
    always_comb begin
        fmask = VLEN'(elem_ones(ew_q)) << (int'(idx_q) << (3 + int'(ew_q)));
        fdata = VLEN'(el_data) << (int'(idx_q) << (3 + int'(ew_q)));
    end

    // operand capture and element datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_UP;   off_q <= '0;  scal_q <= '0;
            ill_q <= 1'b0;   unm_q <= 1'b0;
            vl_q <= '0;      vlmax_q <= '0; idx_q <= '0; ew_q <= '0;
            src_q <= '0;     old_q <= '0;  mask_q <= '0; res_q <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: if (start) begin
                    op_q    <= dec_op;
                    off_q   <= dec_off;
                    scal_q  <= scalar_in;
                    ill_q   <= !dec_legal;
                    unm_q   <= unmasked;
                    vl_q    <= vl;
                    vlmax_q <= vlmax;
                    ew_q    <= ew_sel;
                    src_q   <= src_img;
                    old_q   <= old_img;
                    mask_q  <= mask_img;
                    res_q   <= old_img;
                    idx_q   <= '0;
                end
                S_RUN: begin
                    idx_q <= idx_q + CW'(1);
                    if (el_wr) res_q <= (res_q & ~fmask) | fdata;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        dst_img = res_q;
        done    = (st_q == S_DONE);
        illegal = (st_q == S_DONE) && ill_q;
    end

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != S_IDLE) |=> ($stable(src_q) && $stable(old_q) && $stable(vl_q)));
    a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (dst_img == old_q));
    a_r9_vl_zero_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (done && vl_q == '0) |-> (dst_img == old_q));
    a_r7_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RUN && !unm_q && !mask_q[idx_q] && idx_q < vl_q) |=> $stable(dst_img));
endmodule

// File: tb/sim_vslide_unit.sv
`timescale 1ns/1ps
module sim_vslide_unit;
    localparam int VLEN = 128;
    localparam int CW   = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [5:0]       func_code = '0;
    logic [2:0]       sub_op = '0;
    logic [4:0]       dst_sel = '0, src_sel = '0, imm_off = '0;
    logic [63:0]      scalar_in = '0;
    logic [CW-1:0]    vl = '0, vlmax = '0;
    logic [1:0]       ew_sel = '0;
    logic             unmasked = 1'b1;
    logic [VLEN-1:0]  src_img = '0, old_img = '0, mask_img = '0;
    logic [VLEN-1:0]  dst_img;
    logic             done, illegal;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    vslide_unit #(.VLEN(VLEN)) u0 (.*);

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // independent model: kind 0 up-by-k, 1 down-by-k, 2 up-by-one, 3 down-by-one
    function automatic logic [VLEN-1:0] model(input int kind, input logic [63:0] off,
        input logic [63:0] sc, input int nvl, input int nmax, input int ew, input bit unm,
        input logic [VLEN-1:0] m, input logic [VLEN-1:0] s, input logic [VLEN-1:0] o);
        int w = 8 << ew;
        logic [63:0] se [16];
        logic [63:0] lim;
        logic [VLEN-1:0] r = o;
        for (int i = 0; i < 16; i++) begin
            se[i] = '0;
            for (int b = 0; b < 64; b++)
                if (b < w && i * w + b < VLEN) se[i][b] = s[i * w + b];
        end
        lim = (off > 64'(nvl)) ? 64'(nvl) : off;
        if (nvl == 0) return o;
        for (int i = 0; i < nmax; i++) begin
            bit doit = 1'b1;
            logic [63:0] v = '0;
            if (i < nvl) begin
                if (!unm && !m[i]) doit = 1'b0;
                else if (kind == 0) begin
                    if (64'(i) < lim) doit = 1'b0; else v = se[i - int'(lim)];
                end else if (kind == 1) begin
                    if (off < 64'(nmax) && 64'(i) + off < 64'(nmax)) v = se[i + int'(off)];
                end else if (kind == 2) begin
                    v = (i == 0) ? sc : se[i - 1];
                end else begin
                    v = (i == nvl - 1) ? sc : se[i + 1];
                end
            end
            if (doit)
                for (int b = 0; b < w; b++) r[i * w + b] = v[b];
        end
        return r;
    endfunction

    task automatic run_op(input logic [5:0] fc, input logic [2:0] so, input logic [4:0] d,
        input logic [4:0] sr, input logic [4:0] im, input logic [63:0] sc, input int nvl,
        input int nmax, input int ew, input bit unm, input logic [VLEN-1:0] m,
        input logic [VLEN-1:0] s, input logic [VLEN-1:0] o, input bit poke,
        output logic [VLEN-1:0] res, output logic ill, output int cyc);
        @(negedge clk);
        func_code = fc; sub_op = so; dst_sel = d; src_sel = sr; imm_off = im;
        scalar_in = sc; vl = CW'(nvl); vlmax = CW'(nmax); ew_sel = 2'(ew);
        unmasked = unm; mask_img = m; src_img = s; old_img = o; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 1000) begin
            if (poke && cyc == 3) begin
                start = 1'b1; src_img = ~s; old_img = ~o; vl = CW'(1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        res = dst_img;
        ill = illegal;
    endtask

    function automatic logic [VLEN-1:0] ramp(input logic [7:0] base);
        logic [VLEN-1:0] r;
        for (int i = 0; i < VLEN / 8; i++) r[i * 8 +: 8] = base + 8'(i);
        return r;
    endfunction

    logic [VLEN-1:0] SRC, OLD;

    // kind: 0/1/2/3 as in model; so chooses offset source
    task automatic t_basic(input string req, input int kind, input logic [2:0] so,
        input logic [4:0] im, input logic [63:0] sc, input int nvl, input int nmax,
        input int ew, input bit unm, input logic [VLEN-1:0] m, input bit poke);
        logic [VLEN-1:0] res, exp;
        logic ill;
        int cyc;
        logic [63:0] off = (so == 3'b011) ? 64'(im) : sc;
        logic [63:0] wm = (ew == 3) ? '1 : ((64'd1 << (8 << ew)) - 1);
        run_op((kind == 0 || kind == 2) ? 6'b001110 : 6'b001111, so, 5'd4, 5'd8, im, sc,
               nvl, nmax, ew, unm, m, SRC, OLD, poke, res, ill, cyc);
        exp = model(kind, off, sc & wm, nvl, nmax, ew, unm, m, SRC, OLD);
        chk(res == exp, req, res, exp);
        chk(ill == 1'b0, {req, " R1 legal"}, VLEN'(ill), '0);
        chk(cyc == nmax + 1, {req, " R11 latency"}, VLEN'(cyc), VLEN'(nmax + 1));
    endtask

    task automatic t_illegal(input string req, input logic [5:0] fc, input logic [2:0] so,
        input logic [4:0] d, input logic [4:0] sr);
        logic [VLEN-1:0] res;
        logic ill;
        int cyc;
        run_op(fc, so, d, sr, 5'd2, 64'd1, 8, 16, 0, 1'b1, '0, SRC, OLD, 1'b0, res, ill, cyc);
        chk(ill == 1'b1, {req, " flag"}, VLEN'(ill), VLEN'(1));
        chk(res == OLD, {req, " no write"}, res, OLD);
        chk(cyc == 1, {req, " R11 latency"}, VLEN'(cyc), VLEN'(1));
    endtask

    task automatic t_vl_zero();
        logic [VLEN-1:0] res;
        logic ill;
        int cyc;
        run_op(6'b001111, 3'b100, 5'd1, 5'd2, 5'd0, 64'd1, 0, 16, 0, 1'b1, '0, SRC, OLD, 1'b0, res, ill, cyc);
        chk(res == OLD, "R9 vl zero keeps image", res, OLD);
        chk(cyc == 1, "R9 R11 vl zero latency", VLEN'(cyc), VLEN'(1));
    endtask

    task automatic t_done_pulse();
        @(negedge clk);
        chk(done == 1'b0, "R11 done single cycle", VLEN'(done), '0);
    endtask

    initial begin
        SRC = ramp(8'hA0);
        OLD = ramp(8'h50);
        repeat (3) @(negedge clk);
        chk(dst_img == '0, "reset image", dst_img, '0);
        chk(done == 1'b0 && illegal == 1'b0, "reset flags", VLEN'({done, illegal}), '0);
        rst_n = 1'b1;

        t_basic("R2 up scalar k=3", 0, 3'b100, 5'd0, 64'd3, 10, 16, 0, 1'b1, '0, 1'b0);
        t_done_pulse();
        t_basic("R3 up imm clamp 31", 0, 3'b011, 5'd31, 64'd0, 10, 16, 0, 1'b1, '0, 1'b0);
        t_basic("R1 up imm k=2", 0, 3'b011, 5'd2, 64'hFFFF, 12, 16, 0, 1'b1, '0, 1'b0);
        t_basic("R4 down k=5", 1, 3'b100, 5'd0, 64'd5, 14, 16, 0, 1'b1, '0, 1'b0);
        t_basic("R4 down huge k", 1, 3'b100, 5'd0, 64'h1_0000_0001, 12, 16, 0, 1'b1, '0, 1'b0);
        t_basic("R5 R12 up1 ew16", 2, 3'b110, 5'd0, 64'h1234_5678, 6, 8, 1, 1'b1, '0, 1'b0);
        t_basic("R6 R12 dn1 ew32", 3, 3'b110, 5'd0, 64'hCAFE_0000_BEEF_1111, 3, 4, 2, 1'b1, '0, 1'b0);
        t_basic("R7 masked down k=1", 1, 3'b100, 5'd0, 64'd1, 13, 16, 0, 1'b0, 128'hA5A5, 1'b0);
        t_basic("R7 masked up1", 2, 3'b110, 5'd0, 64'h77, 16, 16, 0, 1'b0, 128'h3C0F, 1'b0);
        t_basic("R8 short vlmax", 1, 3'b011, 5'd1, 64'd0, 5, 8, 0, 1'b1, '0, 1'b0);
        t_basic("R12 up1 ew64", 2, 3'b110, 5'd0, 64'h0123_4567_89AB_CDEF, 1, 2, 3, 1'b1, '0, 1'b0);
        t_basic("R11 start while busy", 0, 3'b100, 5'd0, 64'd2, 16, 16, 0, 1'b1, '0, 1'b1);
        t_vl_zero();
        t_illegal("R10 up same reg", 6'b001110, 3'b100, 5'd6, 5'd6);
        t_illegal("R10 up1 same reg", 6'b001110, 3'b110, 5'd9, 5'd9);
        t_illegal("R1 bad sub_op", 6'b001111, 3'b000, 5'd1, 5'd2);
        t_illegal("R1 bad func_code", 6'b001100, 3'b100, 5'd1, 5'd2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule